// File: doc/BRIEF.md
# Actuator Retract Timing Sequencer

This block sequences the emergency park of a voice-coil actuator. A retract is launched either by software raising a retract control bit or by a low-supply condition. Once launched, the block times a retract window by counting enable pulses from a slow (about 200 kHz) oscillator. A two-bit field selects one of four window lengths, and another two-bit field selects one of four park-level codes for the analog drive stage. At the start of the window the coil can optionally be held in high impedance or short-braked, for exactly the first half of the window. The coil is then driven at the park level for the rest of the window.

When the window completes, the block emits a single-cycle pulse that asks the spindle stage to begin dynamic braking. A retract started by software is abandoned as soon as software drops the retract bit. A retract started by a supply failure always runs to the end. All settings are captured at the moment of launch, so changes to them during a window have no effect.

Top module: `park_retract_seq`

## Requirements
- R1: While idle, a 0-to-1 change of `swRetract` or of `powerFail` between consecutive clock edges starts a retract, and `busy` is high from the next cycle. A level that is already high when reset is released counts as a rise. If both inputs rise together, the retract is treated as power-fail initiated.
- R2: The window lasts a number of `tickEn` cycles that depends on `timeSel`, counted after the start edge. The mapping is 2'b10 → SHORT_TICKS (16000), 2'b00 and 2'b11 → MID_TICKS (32000), and 2'b01 → LONG_TICKS (64000). `busy` falls on the cycle after the last tick. Cycles without `tickEn` do not advance the window.
- R3: `parkCode` takes the `parkSel` value captured at launch. It is stable for the whole window and is held after the window ends. It is 0 after reset.
- R4: `coilMode` encodes 0 = off, 1 = park drive, 2 = high impedance and 3 = short brake. The first floor(L/2) ticks of a window of L ticks form the half-time phase. During that phase, `coilMode` is 3 if `brakeOpt` was set at launch, else 2 if `hizOpt` was set at launch, else 1. For the rest of the window `coilMode` is 1. While idle it is 0.
- R5: `done` is high for exactly one cycle, the cycle in which `busy` falls after the final tick. It is never high at any other time.
- R6: Rises of `swRetract` or `powerFail` while a retract is running are ignored. They neither restart nor lengthen the window.
- R7: For a software-initiated retract, `swRetract` seen low at a clock edge ends the window at that edge. `busy` is low on the next cycle, no `done` pulse is issued, and the tick count is discarded. This takes precedence over a final tick on the same edge.
- R8: A power-fail initiated retract ignores `swRetract` entirely and always runs to completion with a `done` pulse.
- R9: Settings (`timeSel`, `parkSel`, `hizOpt`, `brakeOpt`) changed during a window have no effect on that window.
- R10: During and right after reset, `busy`, `done`, `coilMode` and `parkCode` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| swRetract | input | 1 | Software retract control bit |
| powerFail | input | 1 | Low-supply (power-on-reset) condition |
| tickEn | input | 1 | One-cycle pulse per slow-oscillator period |
| timeSel | input | 2 | Retract duration select |
| parkSel | input | 2 | Park-level select |
| hizOpt | input | 1 | High-impedance half-time option |
| brakeOpt | input | 1 | Short-brake half-time option (wins over hizOpt) |
| busy | output | 1 | Retract window running |
| done | output | 1 | One-cycle spindle-brake request at window end |
| coilMode | output | 2 | Coil drive mode: 0 off, 1 park, 2 high-Z, 3 brake |
| parkCode | output | 2 | Captured park-level code for the analog stage |

## Verification
The properties assume that `swRetract`, `powerFail` and `tickEn` are synchronous to `clk`. They also assume that the selected window length is at least two ticks, so that a half phase and a final tick are distinct. The stimulus drives every input just after the falling edge and uses reduced window lengths of 10, 20 and 40 ticks. It varies tick density between every cycle and roughly one cycle in three. It also changes the captured settings mid-window and pulses both triggers during running windows, so the capture and ignore rules are exercised alongside the cancel path.

// File: rtl/park_pkg.sv
package park_pkg;
  typedef enum logic [1:0] {
    COIL_OFF   = 2'd0,
    COIL_PARK  = 2'd1,
    COIL_HIZ   = 2'd2,
    COIL_BRAKE = 2'd3
  } coil_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture settings, zero the counter
    logic clear;  // zero the counter
    logic step;   // advance the counter by one tick
  } seqCmd_t;
endpackage

// File: rtl/park_dp.sv
module park_dp
  import park_pkg::*;
#(
  parameter int SHORT_TICKS = 16000,
  parameter int MID_TICKS   = 32000,
  parameter int LONG_TICKS  = 64000,
  parameter int CNT_W       = $clog2(LONG_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCmd_t          cmd,
  input  logic [1:0]       timeSel,
  input  logic [1:0]       parkSel,
  input  logic             hizOpt,
  input  logic             brakeOpt,
  output logic             lastTick,
  output logic             firstHalf,
  output logic [1:0]       parkCode,
  output coil_e            optMode
);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LEN_MID   = CNT_W'(MID_TICKS);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(LONG_TICKS);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] winLen;
  logic [CNT_W-1:0] winLenNext;
  logic [CNT_W-1:0] halfLen;
  coil_e            optNext;

  // non-monotonic duration encoding
  always_comb begin
    unique case (timeSel)
      2'b00:   winLenNext = LEN_MID;
      2'b01:   winLenNext = LEN_LONG;
      2'b10:   winLenNext = LEN_SHORT;
      default: winLenNext = LEN_MID;
    endcase
  end

  // brake wins over high impedance
  always_comb begin
    if (brakeOpt)    optNext = COIL_BRAKE;
    else if (hizOpt) optNext = COIL_HIZ;
    else             optNext = COIL_PARK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt  <= '0;
      winLen   <= LEN_MID;
      parkCode <= 2'b00;
      optMode  <= COIL_PARK;
    end else if (cmd.load) begin
      tickCnt  <= '0;
      winLen   <= winLenNext;
      parkCode <= parkSel;
      optMode  <= optNext;
    end else if (cmd.clear) begin
      tickCnt  <= '0;
    end else if (cmd.step) begin
      tickCnt  <= tickCnt + ONE;
    end
  end

  assign halfLen   = winLen >> 1;
  assign lastTick  = (tickCnt == winLen - ONE);
  assign firstHalf = (tickCnt < halfLen);
endmodule

// File: rtl/park_ctrl.sv
module park_ctrl
  import park_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    swRetract,
  input  logic    powerFail,
  input  logic    tickEn,
  input  logic    lastTick,
  input  logic    firstHalf,
  input  coil_e   optMode,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    done,
  output coil_e   coilMode
);
  logic running;
  logic pfCause;
  logic swPrev;
  logic pfPrev;
  logic doneQ;
  logic swRise;
  logic pfRise;
  logic cancel;
  logic finish;

  assign swRise = swRetract & ~swPrev;
  assign pfRise = powerFail & ~pfPrev;
  // software may abandon only its own retract
  assign cancel = running & ~pfCause & ~swRetract;
  assign finish = running & ~cancel & tickEn & lastTick;

  always_comb begin
    cmd = '0;
    if (!running) begin
      cmd.load = swRise | pfRise;
    end else if (cancel || finish) begin
      cmd.clear = 1'b1;
    end else begin
      cmd.step = tickEn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      pfCause <= 1'b0;
      swPrev  <= 1'b0;
      pfPrev  <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      swPrev <= swRetract;
      pfPrev <= powerFail;
      doneQ  <= finish;
      if (!running) begin
        if (swRise || pfRise) begin
          running <= 1'b1;
          pfCause <= pfRise;
        end
      end else if (cancel || finish) begin
        running <= 1'b0;
        pfCause <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!running)       coilMode = COIL_OFF;
    else if (firstHalf) coilMode = optMode;
    else                coilMode = COIL_PARK;
  end

  assign busy = running;
  assign done = doneQ;
endmodule

// File: rtl/park_retract_seq.sv
module park_retract_seq
  import park_pkg::*;
#(
  parameter int SHORT_TICKS = 16000,
  parameter int MID_TICKS   = 32000,
  parameter int LONG_TICKS  = 64000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swRetract,
  input  logic       powerFail,
  input  logic       tickEn,
  input  logic [1:0] timeSel,
  input  logic [1:0] parkSel,
  input  logic       hizOpt,
  input  logic       brakeOpt,
  output logic       busy,
  output logic       done,
  output logic [1:0] coilMode,
  output logic [1:0] parkCode
);
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  seqCmd_t cmd;
  logic    lastTick;
  logic    firstHalf;
  coil_e   optMode;
  coil_e   modeOut;

  park_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .swRetract (swRetract),
    .powerFail (powerFail),
    .tickEn    (tickEn),
    .lastTick  (lastTick),
    .firstHalf (firstHalf),
    .optMode   (optMode),
    .cmd       (cmd),
    .busy      (busy),
    .done      (done),
    .coilMode  (modeOut)
  );

  park_dp #(
    .SHORT_TICKS (SHORT_TICKS),
    .MID_TICKS   (MID_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .timeSel   (timeSel),
    .parkSel   (parkSel),
    .hizOpt    (hizOpt),
    .brakeOpt  (brakeOpt),
    .lastTick  (lastTick),
    .firstHalf (firstHalf),
    .parkCode  (parkCode),
    .optMode   (optMode)
  );

  assign coilMode = modeOut;
endmodule

// File: rtl/park_chk.sv
module park_chk (
  input logic       clk,
  input logic       rstN,
  input logic       swRetract,
  input logic       powerFail,
  input logic       busy,
  input logic       done,
  input logic [1:0] coilMode,
  input logic [1:0] parkCode
);
  // R1: a window only opens after a trigger input was high
  p_start_needs_trigger_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(swRetract) || $past(powerFail)));

  // R3: park code frozen across a running window
  p_code_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(parkCode));

  // R4: idle means coil off
  p_idle_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (coilMode == 2'd0));

  // R4: once park drive begins, the half phase never returns
  p_phase_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && ($past(coilMode) == 2'd1)) |-> (coilMode == 2'd1));

  // R5: done marks the falling edge of busy
  p_done_at_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R5: done lasts one cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: an early end without done needs the software bit low
  p_cancel_needs_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !busy && !done) |-> !$past(swRetract));
endmodule

bind park_retract_seq park_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .swRetract (swRetract),
  .powerFail (powerFail),
  .busy      (busy),
  .done      (done),
  .coilMode  (coilMode),
  .parkCode  (parkCode)
);

// File: tb/sim_park_retract_seq.sv
`timescale 1ns/1ps
module sim_park_retract_seq;
  localparam int SH = 10;
  localparam int MD = 20;
  localparam int LG = 40;
  localparam int WATCHDOG = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swRetract = 1'b0;
  logic       powerFail = 1'b0;
  logic       tickEn = 1'b0;
  logic [1:0] timeSel = 2'b00;
  logic [1:0] parkSel = 2'b00;
  logic       hizOpt = 1'b0;
  logic       brakeOpt = 1'b0;
  logic       busy;
  logic       done;
  logic [1:0] coilMode;
  logic [1:0] parkCode;

  int  nChecks = 0;
  int  nFails = 0;
  int  cycles = 0;
  bit  dense = 1'b1;
  bit  ended = 1'b0;

  // reference model state
  bit  mBusy, mPf, mDone, mSwPrev, mPfPrev;
  int  mCnt, mLen, mOpt, mPark;

  always #4 clk = ~clk;  // 125 MHz

  park_retract_seq #(.SHORT_TICKS(SH), .MID_TICKS(MD), .LONG_TICKS(LG)) u0 (
    .clk(clk), .rstN(rstN), .swRetract(swRetract), .powerFail(powerFail),
    .tickEn(tickEn), .timeSel(timeSel), .parkSel(parkSel), .hizOpt(hizOpt),
    .brakeOpt(brakeOpt), .busy(busy), .done(done), .coilMode(coilMode),
    .parkCode(parkCode)
  );

  function automatic int lenOf(input logic [1:0] s);
    case (s)
      2'b00: return MD;
      2'b01: return LG;
      2'b10: return SH;
      default: return MD;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // behavioural reference, evaluated on each rising edge
  always @(posedge clk) begin
    bit swR, pfR;
    if (!rstN) begin
      mBusy = 0; mPf = 0; mDone = 0; mSwPrev = 0; mPfPrev = 0;
      mCnt = 0; mLen = MD; mOpt = 1; mPark = 0;
    end else begin
      swR = swRetract && !mSwPrev;
      pfR = powerFail && !mPfPrev;
      mDone = 0;
      if (!mBusy) begin
        if (swR || pfR) begin
          mBusy = 1; mPf = pfR; mCnt = 0; mLen = lenOf(timeSel);
          mPark = parkSel;
          mOpt = brakeOpt ? 3 : (hizOpt ? 2 : 1);
        end
      end else if (!mPf && !swRetract) begin
        mBusy = 0; mCnt = 0;
      end else if (tickEn) begin
        mCnt++;
        if (mCnt == mLen) begin
          mBusy = 0; mDone = 1; mCnt = 0;
        end
      end
      mSwPrev = swRetract;
      mPfPrev = powerFail;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    int expMode;
    if (rstN && !ended) begin
      expMode = !mBusy ? 0 : ((mCnt < mLen / 2) ? mOpt : 1);
      check(busy == mBusy, "R1/R2 busy", busy, mBusy);
      check(done == mDone, "R5 done", done, mDone);
      check(coilMode == expMode, "R4 coilMode", coilMode, expMode);
      check(parkCode == mPark, "R3 parkCode", parkCode, mPark);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !ended) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      tickEn = dense ? 1'b1 : ($urandom_range(0, 2) == 0);
    end
  endtask

  // software window with every-cycle ticks; measures length and half phase
  task automatic runWindow(input logic [1:0] sel, input logic [1:0] pk,
                           input bit hz, input bit bk, input string tag);
    int nBusy = 0;
    int nHalf = 0;
    int expOpt;
    int expHalf;
    expOpt = bk ? 3 : (hz ? 2 : 1);
    timeSel = sel; parkSel = pk; hizOpt = hz; brakeOpt = bk;
    swRetract = 1'b1;
    step(1);
    // R9: scramble settings after launch
    timeSel = ~sel; parkSel = ~pk; hizOpt = ~hz; brakeOpt = ~bk;
    while (busy && nBusy < 1000) begin
      nBusy++;
      if (coilMode != 2'd1) nHalf++;
      step(1);
    end
    expHalf = (expOpt == 1) ? 0 : lenOf(sel) / 2;
    check(nBusy == lenOf(sel), {tag, " R2 window ticks"}, nBusy, lenOf(sel));
    check(nHalf == expHalf, {tag, " R4 half phase cycles"}, nHalf, expHalf);
    check(done == 1'b1, {tag, " R5 done at end"}, done, 1);
    check(parkCode == pk, {tag, " R3/R9 captured code"}, parkCode, pk);
    swRetract = 1'b0;
    step(2);
  endtask

  initial begin
    int n;
    rstN = 1'b0;
    step(3);
    check(busy == 0 && done == 0 && coilMode == 0 && parkCode == 0,
          "R10 reset state", {busy, done, coilMode, parkCode}, 0);
    rstN = 1'b1;
    step(2);
    check(busy == 0, "R10 idle after reset", busy, 0);

    runWindow(2'b00, 2'b01, 1'b0, 1'b0, "code00");
    runWindow(2'b01, 2'b10, 1'b1, 1'b0, "code01");
    runWindow(2'b10, 2'b11, 1'b0, 1'b1, "code10");
    runWindow(2'b11, 2'b00, 1'b1, 1'b1, "code11 R4 brake priority");

    // R6: retrigger during a running window
    timeSel = 2'b10; swRetract = 1'b1;
    step(1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 3) powerFail = 1'b1;
      if (n == 5) powerFail = 1'b0;
      step(1);
    end
    check(n == SH, "R6 retrigger ignored", n, SH);
    swRetract = 1'b0;
    step(3);

    // R7: software cancel
    timeSel = 2'b01; swRetract = 1'b1;
    step(6);
    swRetract = 1'b0;
    step(1);
    check(busy == 0, "R7 cancel drops busy", busy, 0);
    check(done == 0, "R7 cancel gives no done", done, 0);
    step(LG + 5);
    check(done == 0 && busy == 0, "R7 no late done", {busy, done}, 0);

    // R8: power-fail retract ignores software bit
    timeSel = 2'b00; powerFail = 1'b1;
    step(1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 2) swRetract = 1'b1;
      if (n == 4) swRetract = 1'b0;
      step(1);
    end
    check(n == MD, "R8 power-fail runs to end", n, MD);
    check(done == 1'b1, "R8 done after power-fail", done, 1);
    powerFail = 1'b0;
    step(3);

    // R1: both triggers rise together -> power-fail cause, cannot cancel
    timeSel = 2'b10; swRetract = 1'b1; powerFail = 1'b1;
    step(2);
    swRetract = 1'b0;
    step(1);
    check(busy == 1, "R1 joint rise is power-fail", busy, 1);
    step(SH + 2);
    powerFail = 1'b0;
    step(2);

    // randomized regression under sparse ticks, model compares each cycle
    dense = 1'b0;
    for (int it = 0; it < 40; it++) begin
      timeSel = 2'($urandom_range(0, 3));
      parkSel = 2'($urandom_range(0, 3));
      hizOpt = 1'($urandom_range(0, 1));
      brakeOpt = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) powerFail = 1'b1; else swRetract = 1'b1;
      step($urandom_range(1, 60));
      timeSel = 2'($urandom_range(0, 3));
      parkSel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) swRetract = 1'b0;
      step($urandom_range(1, 80));
      swRetract = 1'b0; powerFail = 1'b0;
      step($urandom_range(2, 130));
    end
    step(5);
    finishRun();
  end
endmodule